// File: doc/BRIEF.md
# Receiver Error Logger with Sample Conditioning

This block sits behind a digital audio receiver front end. Each audio sample arrives with a set of error flags: loss of clock lock, the validity flag, a line-coding fault, a parity fault, and two checksum faults. A per-bit enable register decides which of these errors count. An enabled error is recorded in a sticky log bit. It also raises a one-clock pulse and keeps an interrupt line high. It can also change the sample that leaves the block.

The log bits stay set until software reads the log, and the read clears them. Errors that are disabled leave no trace. The two checksum faults are never allowed to change audio, even when they are enabled. For the other errors, a two-bit mode picks the treatment of the outgoing sample: pass it unchanged, repeat the last delivered sample, or replace it with zero.

Top module: `rx_err_log`

## Requirements
- R1: After reset, err_log is 0, err_irq is 0, err_pulse is 0, sample_out_vld is 0 and sample_out is 0.
- R2: An error flag is taken only in a cycle with sample_vld=1 and err_mask bit=1. It sets the matching err_log bit in the next cycle. Bit positions: 0 lock lost, 1 validity, 2 line coding, 3 parity, 4 first checksum, 5 second checksum. Flags in cycles with sample_vld=0 have no effect.
- R3: A set err_log bit stays set in every following cycle until a cycle with reg_rd=1.
- R4: A cycle with reg_rd=1 clears err_log in the next cycle. The exception is any bit whose enabled error arrives in that same cycle: that bit is set after the read.
- R5: An error whose err_mask bit is 0 does not set err_log, does not pulse err_pulse and does not change sample_out.
- R6: err_pulse is high for exactly the one cycle after each accepted sample that carries at least one enabled error, and is low otherwise.
- R7: err_irq is high exactly while err_log is nonzero.
- R8: Mode pass (hold_mode 2'b00) or reserved (2'b11): sample_out takes sample_in one cycle after the sample, even when an enabled error is present.
- R9: Mode repeat (hold_mode 2'b01): a sample with an enabled non-checksum error leaves sample_out at its previous value.
- R10: Mode zero (hold_mode 2'b10): a sample with an enabled non-checksum error makes sample_out 0.
- R11: Enabled errors on bits 4 and 5 alone never change the sample; sample_in passes through in every mode.
- R12: sample_out_vld is sample_vld delayed by one cycle. sample_out keeps its value in cycles after sample_vld=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Marks a sample and its error flags |
| sample_in | input | SAMPLE_W | Incoming audio sample |
| err_flags | input | 6 | Per-sample error flags |
| err_mask | input | 6 | Per-bit enable, 1 means the error counts |
| hold_mode | input | 2 | Treatment of a faulty sample |
| reg_rd | input | 1 | Log read strobe, clears the log |
| err_log | output | 6 | Sticky error log |
| err_irq | output | 1 | Interrupt, high while the log is nonzero |
| err_pulse | output | 1 | One-clock pulse per faulty sample |
| sample_out_vld | output | 1 | Marks a conditioned sample |
| sample_out | output | SAMPLE_W | Conditioned audio sample |

## Verification
Every registered result (err_log, err_pulse, sample_out_vld and sample_out) is due exactly one clock after the edge that takes the stimulus. err_irq follows err_log within that same cycle. The bench drives each stimulus one nanosecond after a rising edge and waits for the next rising edge. It then samples one nanosecond later, after the bench model has advanced by the same single step. Directed cases cover a read that coincides with a new error, checksum-only errors in the zero mode, and repeat chains. Random cycles then mix all the modes and enable patterns.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int ERR_W      = 6;
  localparam int IDX_UNLOCK = 0;
  localparam int IDX_VALID  = 1;
  localparam int IDX_CODING = 2;
  localparam int IDX_PARITY = 3;
  localparam int IDX_CRC_A  = 4;
  localparam int IDX_CRC_B  = 5;
  localparam logic [ERR_W-1:0] CRC_CLASS = ERR_W'((1 << IDX_CRC_A) | (1 << IDX_CRC_B));

  typedef enum logic [1:0] {
    HOLD_PASS   = 2'b00,
    HOLD_REPEAT = 2'b01,
    HOLD_MUTE   = 2'b10,
    HOLD_RSVD   = 2'b11
  } hold_mode_e;
endpackage

// File: rtl/rx_err_gate.sv
module rx_err_gate
  import rx_err_pkg::*;
#(
  parameter int                W        = ERR_W,
  parameter logic [W-1:0]      NO_SUBST = CRC_CLASS
) (
  input  logic         vld,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enable,
  output logic [W-1:0] hit,
  output logic         any_hit,
  output logic         affect
);
  logic [W-1:0] subst;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign hit[i] = vld & flags[i] & enable[i];
    if (NO_SUBST[i]) begin : g_keep
      assign subst[i] = 1'b0;
    end else begin : g_alter
      assign subst[i] = hit[i];
    end
  end

  assign any_hit = |hit;
  assign affect  = |subst;
endmodule

// File: rtl/rx_err_sticky.sv
module rx_err_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic [W-1:0] hit,
  output logic [W-1:0] log_q
);
  logic [W-1:0] log_d;
  logic         log_en;

  always_comb begin
    log_en = rd | (|hit);
    log_d  = (rd ? '0 : log_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      log_q <= '0;
    else if (log_en) log_q <= log_d;
  end

  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((log_q & $past(log_q)) == $past(log_q)));

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((log_q & $past(hit)) == $past(hit)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit == '0) |=> (log_q == '0));
endmodule

// File: rtl/rx_err_pulse.sv
module rx_err_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic any_hit,
  output logic pulse_q
);
  logic pulse_d;

  always_comb pulse_d = any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end
endmodule

// File: rtl/rx_sample_cond.sv
module rx_sample_cond
  import rx_err_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [SW-1:0] din,
  input  logic [1:0]    hold,
  input  logic          affect,
  output logic          vld_q,
  output logic [SW-1:0] dout_q
);
  hold_mode_e    mode;
  logic [SW-1:0] dout_d;
  logic          dout_en;

  always_comb begin
    mode    = hold_mode_e'(hold);
    dout_en = vld;
    dout_d  = din;
    if (affect) begin
      case (mode)
        HOLD_REPEAT: dout_d = dout_q;
        HOLD_MUTE:   dout_d = '0;
        default:     dout_d = din;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      vld_q <= vld;
      if (dout_en) dout_q <= dout_d;
    end
  end

  assert_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && affect && hold == 2'b01) |=> $stable(dout_q));

  assert_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && affect && hold == 2'b10) |=> (dout_q == '0));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> (!vld_q && $stable(dout_q)));
endmodule

// File: rtl/rx_err_log.sv
module rx_err_log
  import rx_err_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_vld,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [ERR_W-1:0]    err_flags,
  input  logic [ERR_W-1:0]    err_mask,
  input  logic [1:0]          hold_mode,
  input  logic                reg_rd,
  output logic [ERR_W-1:0]    err_log,
  output logic                err_irq,
  output logic                err_pulse,
  output logic                sample_out_vld,
  output logic [SAMPLE_W-1:0] sample_out
);
  logic [ERR_W-1:0] hit;
  logic             any_hit;
  logic             affect;

  rx_err_gate #(.W(ERR_W), .NO_SUBST(CRC_CLASS)) u_gate (
    .vld     (sample_vld),
    .flags   (err_flags),
    .enable  (err_mask),
    .hit     (hit),
    .any_hit (any_hit),
    .affect  (affect)
  );

  rx_err_sticky #(.W(ERR_W)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (reg_rd),
    .hit   (hit),
    .log_q (err_log)
  );

  rx_err_pulse u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_hit (any_hit),
    .pulse_q (err_pulse)
  );

  rx_sample_cond #(.SW(SAMPLE_W)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (sample_vld),
    .din    (sample_in),
    .hold   (hold_mode),
    .affect (affect),
    .vld_q  (sample_out_vld),
    .dout_q (sample_out)
  );

  assign err_irq = |err_log;

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> err_pulse);

  assert_pulse_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(sample_vld));

  assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_flags & err_mask) == '0 && !reg_rd) |=> ($stable(err_log) && !err_pulse));

  assert_crc_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && (err_flags & err_mask & ~CRC_CLASS) == '0) |=> (sample_out == $past(sample_in)));
endmodule

// File: tb/rx_err_log_test.sv
`timescale 1ns/1ps
module rx_err_log_test;
  localparam int SW = 24;
  localparam int EW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sample_vld;
  logic [SW-1:0] sample_in;
  logic [EW-1:0] err_flags;
  logic [EW-1:0] err_mask;
  logic [1:0]    hold_mode;
  logic          reg_rd;
  logic [EW-1:0] err_log;
  logic          err_irq;
  logic          err_pulse;
  logic          sample_out_vld;
  logic [SW-1:0] sample_out;

  int n_checks = 0;
  int n_errs   = 0;

  logic [EW-1:0] m_log;
  logic          m_pulse;
  logic          m_vld;
  logic [SW-1:0] m_out;

  always #2.5 clk = ~clk;

  rx_err_log #(.SAMPLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample_in(sample_in),
    .err_flags(err_flags), .err_mask(err_mask), .hold_mode(hold_mode),
    .reg_rd(reg_rd), .err_log(err_log), .err_irq(err_irq), .err_pulse(err_pulse),
    .sample_out_vld(sample_out_vld), .sample_out(sample_out)
  );

  function automatic logic [SW-1:0] exp_sample(input logic vld, input logic [SW-1:0] d,
      input logic [EW-1:0] e, input logic [EW-1:0] m, input logic [1:0] h,
      input logic [SW-1:0] prev);
    logic alter;
    alter = vld && ((e & m & 6'b001111) != '0);
    if (!vld)                   return prev;
    if (alter && h == 2'b01)    return prev;
    if (alter && h == 2'b10)    return '0;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string sreq);
    check(err_log == m_log, "R2/R3/R4 err_log", 32'(err_log), 32'(m_log));
    check(err_irq == (m_log != '0), "R7 err_irq", 32'(err_irq), 32'(m_log != '0));
    check(err_pulse == m_pulse, "R6 err_pulse", 32'(err_pulse), 32'(m_pulse));
    check(sample_out_vld == m_vld, "R12 sample_out_vld", 32'(sample_out_vld), 32'(m_vld));
    check(sample_out == m_out, sreq, 32'(sample_out), 32'(m_out));
  endtask

  task automatic step(input logic vld, input logic [SW-1:0] d, input logic [EW-1:0] e,
      input logic [EW-1:0] m, input logic [1:0] h, input logic rd, input string sreq);
    logic [EW-1:0] hit;
    sample_vld = vld; sample_in = d; err_flags = e; err_mask = m; hold_mode = h; reg_rd = rd;
    @(posedge clk);
    #1;
    hit     = vld ? (e & m) : '0;
    m_log   = (rd ? '0 : m_log) | hit;
    m_pulse = (hit != '0);
    m_out   = exp_sample(vld, d, e, m, h, m_out);
    m_vld   = vld;
    compare_all(sreq);
  endtask

  initial begin
    #(200000 * 5);
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    sample_vld = 0; sample_in = '0; err_flags = '0; err_mask = '0; hold_mode = 2'b00; reg_rd = 0;
    m_log = '0; m_pulse = 0; m_vld = 0; m_out = '0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 sample_out reset");
    rst_n = 1'b1;

    // R2: each bit lands in its own position
    step(1, 24'h111111, 6'b000001, 6'b111111, 2'b00, 0, "R8 pass");
    step(1, 24'h222222, 6'b100000, 6'b111111, 2'b00, 0, "R8 pass");
    // R2: flags without sample_vld ignored
    step(0, 24'h333333, 6'b000110, 6'b111111, 2'b10, 0, "R12 idle keeps sample");
    // R3: hold without read
    step(1, 24'h444444, 6'b000000, 6'b111111, 2'b00, 0, "R3 quiet sample");
    // R4: clearing read
    step(0, 24'h0, 6'b000000, 6'b111111, 2'b00, 1, "R4 read");
    // R4: read coinciding with an error
    step(1, 24'h0, 6'b001000, 6'b111111, 2'b00, 0, "R8 pass");
    step(1, 24'h555555, 6'b000100, 6'b111111, 2'b00, 1, "R4 read with new error");
    // R5: masked error no effect, even in mute mode
    step(1, 24'h666666, 6'b001111, 6'b110000, 2'b10, 1, "R5 masked");
    step(1, 24'h777777, 6'b001111, 6'b000000, 2'b10, 0, "R5 masked sample passes");
    // R10: mute
    step(1, 24'h888888, 6'b000010, 6'b111111, 2'b10, 0, "R10 mute");
    // R11: checksum errors only never alter the sample
    step(1, 24'h999999, 6'b110000, 6'b111111, 2'b10, 0, "R11 crc in mute mode");
    step(1, 24'haaaaaa, 6'b010000, 6'b111111, 2'b01, 0, "R11 crc in repeat mode");
    // R9: repeat chain
    step(1, 24'hbbbbbb, 6'b000001, 6'b111111, 2'b01, 0, "R9 repeat");
    step(1, 24'hcccccc, 6'b001000, 6'b111111, 2'b01, 0, "R9 repeat again");
    // R8: reserved mode passes
    step(1, 24'hdddddd, 6'b001111, 6'b111111, 2'b11, 1, "R8 reserved mode");
    step(0, 24'h0, 6'b000000, 6'b000000, 2'b00, 1, "R7 cleared");

    for (int i = 0; i < 3000; i++) begin
      logic [EW-1:0] e;
      e = ($urandom % 3 == 0) ? EW'($urandom) : '0;
      step(($urandom % 4) != 0, SW'($urandom), e, EW'($urandom), 2'($urandom),
           ($urandom % 8) == 0, "R8/R9/R10/R11 random sample");
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule